// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the serial clock waveform of an I2C master. It alternates a low phase, in which it pulls the SCL line down, with a released phase, in which the line floats high through its pull-up. Each phase length is set by a programmed cycle count. There are two count pairs, one for standard mode and one for fast mode, and a select pin picks the pair in use. The block adds fixed overhead cycles to the programmed counts. The low phase starts counting on the cycle the block starts pulling. Bus fall time therefore eats into that phase, and software should add the fall time to its low-time target before it converts that target to cycles.

The block senses the line through a two-stage synchronizer. In the released phase the high count only starts once the line is seen high, so a target that stretches the clock lengthens the phase. The count values and the mode select are captured only while the block is disabled. Changes made while it is running are held off until the next disable. The sequencing of START, STOP and data bits is left to the surrounding controller.

Top module: `scl_period_gen`

## Requirements
- R1: Out of reset `scl_pull` is 0, so the line is released.
- R2: Whenever `enable` is sampled 0, `scl_pull` is 0 from the next cycle. When `enable` is then sampled 1, a fresh low phase begins: `scl_pull` rises on the next cycle and the low phase runs its full length.
- R3: A low phase holds `scl_pull` at 1 for exactly L+1 clock cycles, where L is the effective low count of the selected pair.
- R4: When the line rises as soon as it is released, the released phase holds `scl_pull` at 0 for exactly H+8 cycles, where H is the effective high count of the selected pair.
- R5: When a target holds the line low after release, the released phase ends H+7 cycles after the first clock edge at which `scl_in` is sampled high.
- R6: `fast_sel` = 1 selects the pair `fast_hi_cnt`/`fast_lo_cnt`, and `fast_sel` = 0 selects the pair `std_hi_cnt`/`std_lo_cnt`.
- R7: A programmed count below 6 acts as 6. The shortest low phase is therefore 7 cycles and the shortest released phase is 14 cycles.
- R8: The four counts and `fast_sel` are sampled only on edges where `enable` is 0. Changes to them while enabled have no effect on the waveform until the block has been disabled for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; when 0 the line is released and the configuration is captured |
| fast_sel | input | 1 | 1 = fast-mode count pair, 0 = standard-mode count pair |
| std_hi_cnt | input | 16 | Standard-mode high count |
| std_lo_cnt | input | 16 | Standard-mode low count |
| fast_hi_cnt | input | 16 | Fast-mode high count |
| fast_lo_cnt | input | 16 | Fast-mode low count |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_pull | output | 1 | Open-drain drive: 1 pulls SCL low, 0 releases it |

## Verification
The hardest case to reach from the ports is clock stretching. The line must stay low after the block releases it, and the phase end then depends on the exact edge at which the synchronizer first sees the line high. The bench models the wired line as the inverse of `scl_pull` AND-ed with a stretch signal. It keeps the stretch signal asserted through the low phase and drops it a set number of cycles after the release. The expected released length follows from R5. A second hard case is a disable that lands in the middle of a low phase and is followed at once by a re-enable. The bench times both edges at falling clock edges and checks that the next low phase runs its full length.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // Phase of the generated clock.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  // Fixed cycles added to the programmed counts.
  localparam int unsigned LO_EXTRA = 1;
  localparam int unsigned HI_EXTRA = 8;

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold #(
  parameter int CW      = 16,
  parameter int MIN_CNT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          fast_sel,
  input  logic [CW-1:0] std_hi,
  input  logic [CW-1:0] std_lo,
  input  logic [CW-1:0] fast_hi,
  input  logic [CW-1:0] fast_lo,
  output logic [CW-1:0] hi_lim,
  output logic [CW-1:0] lo_lim
);
  localparam logic [CW-1:0] FLOOR = CW'(MIN_CNT);

  function automatic logic [CW-1:0] floor_cnt(input logic [CW-1:0] v);
    return (v < FLOOR) ? FLOOR : v;
  endfunction

  logic [CW-1:0] hi_raw [2];
  logic [CW-1:0] lo_raw [2];
  logic [CW-1:0] hi_q   [2];
  logic [CW-1:0] lo_q   [2];
  logic          mode_q;

  assign hi_raw[0] = std_hi;
  assign lo_raw[0] = std_lo;
  assign hi_raw[1] = fast_hi;
  assign lo_raw[1] = fast_lo;

  // One capture register pair per speed mode, loaded only while stopped.
  for (genvar g = 0; g < 2; g++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[g] <= FLOOR;
        lo_q[g] <= FLOOR;
      end else if (!enable) begin
        hi_q[g] <= floor_cnt(hi_raw[g]);
        lo_q[g] <= floor_cnt(lo_raw[g]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (!enable) mode_q <= fast_sel;
  end

  assign hi_lim = hi_q[mode_q];
  assign lo_lim = lo_q[mode_q];
endmodule

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CW-1:0] hi_lim,
  input  logic [CW-1:0] lo_lim,
  input  logic          line_high,
  output logic          pull_low
);
  localparam int CNTW = CW + 1;
  // Released cycles spent before counting: the release edge plus the synchronizer.
  localparam int HI_TAIL = int'(HI_EXTRA) - 1 - SYNC_STAGES;
  localparam logic [CNTW-1:0] HI_ADD = CNTW'(HI_TAIL - 1);

  scl_phase_e      ph_q, ph_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [CNTW-1:0] lo_end, hi_end;

  assign lo_end = {1'b0, lo_lim};
  assign hi_end = {1'b0, hi_lim} + HI_ADD;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q + 1'b1;
    if (!enable) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_d  = PH_LOW;
          cnt_d = '0;
        end
        PH_LOW: begin
          if (cnt_q == lo_end) begin
            ph_d  = PH_WAIT;
            cnt_d = '0;
          end
        end
        PH_WAIT: begin
          cnt_d = '0;
          if (line_high) ph_d = PH_HIGH;
        end
        PH_HIGH: begin
          if (cnt_q == hi_end) begin
            ph_d  = PH_LOW;
            cnt_d = '0;
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign pull_low = (ph_q == PH_LOW);
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CW          = 16,
  parameter int MIN_CNT     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          fast_sel,
  input  logic [CW-1:0] std_hi_cnt,
  input  logic [CW-1:0] std_lo_cnt,
  input  logic [CW-1:0] fast_hi_cnt,
  input  logic [CW-1:0] fast_lo_cnt,
  input  logic          scl_in,
  output logic          scl_pull
);
  logic [CW-1:0] hi_lim, lo_lim;
  logic          line_high;

  scl_cfg_hold #(.CW(CW), .MIN_CNT(MIN_CNT)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .fast_sel(fast_sel),
    .std_hi  (std_hi_cnt),
    .std_lo  (std_lo_cnt),
    .fast_hi (fast_hi_cnt),
    .fast_lo (fast_lo_cnt),
    .hi_lim  (hi_lim),
    .lo_lim  (lo_lim)
  );

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (scl_in),
    .q    (line_high)
  );

  scl_phase_fsm #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .hi_lim   (hi_lim),
    .lo_lim   (lo_lim),
    .line_high(line_high),
    .pull_low (scl_pull)
  );
endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_pull
);
  logic [16:0] lo_run, hi_run;
  logic        seen_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run   <= '0;
      hi_run   <= '0;
      seen_low <= 1'b0;
    end else begin
      lo_run   <= scl_pull ? ((&lo_run) ? lo_run : lo_run + 1'b1) : '0;
      seen_low <= enable && (seen_low || scl_pull);
      hi_run   <= (!scl_pull && enable && seen_low) ?
                  ((&hi_run) ? hi_run : hi_run + 1'b1) : '0;
    end
  end

  // R2: a sampled low enable releases the line on the next cycle.
  p_idle_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_pull);

  // R2: a sampled rise of enable starts a low phase on the next cycle.
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !$past(enable)) |=> scl_pull);

  // R3, R7: an undisturbed low phase never lasts fewer than 7 cycles.
  p_min_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull && lo_run != 0 && $past(enable)) |-> (lo_run >= 17'd7));

  // R4, R7: a released phase between two low phases never lasts fewer than 14 cycles.
  p_min_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && hi_run != 0) |-> (hi_run >= 17'd14));
endmodule

bind scl_period_gen scl_period_gen_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .enable  (enable),
  .scl_pull(scl_pull)
);

// File: tb/scl_period_gen_test.sv
`timescale 1ns/1ps
module scl_period_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        fast_sel = 1'b0;
  logic [15:0] std_hi = 16'd20, std_lo = 16'd30;
  logic [15:0] fast_hi = 16'd9, fast_lo = 16'd12;
  logic        stretch = 1'b0;
  logic        scl_pull;
  logic        scl_line;
  int          checks = 0, failures = 0;
  int          stretch_cycles = 0;

  always #2.5 clk = ~clk;

  // Wired-AND line: pulled low by the block or by a stretching target.
  assign scl_line = !scl_pull && !stretch;

  scl_period_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_sel(fast_sel),
    .std_hi_cnt(std_hi), .std_lo_cnt(std_lo),
    .fast_hi_cnt(fast_hi), .fast_lo_cnt(fast_lo),
    .scl_in(scl_line), .scl_pull(scl_pull)
  );

  // Target model: holds the line through the low phase, lets go N cycles after release.
  initial begin
    int sc;
    sc = 0;
    forever begin
      @(negedge clk);
      if (stretch_cycles == 0) begin stretch = 1'b0; sc = 0; end
      else if (scl_pull) begin stretch = 1'b1; sc = 0; end
      else if (stretch) begin
        sc++;
        if (sc == stretch_cycles) stretch = 1'b0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Measures one full low phase and the released phase that follows it.
  task automatic measure(output int lo, output int hi);
    lo = 0; hi = 0;
    @(negedge clk);
    while (scl_pull) @(negedge clk);
    while (!scl_pull) @(negedge clk);
    while (scl_pull) begin lo++; @(negedge clk); end
    while (!scl_pull) begin hi++; @(negedge clk); end
  endtask

  task automatic stop_gen();
    @(negedge clk); enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset release", int'(scl_pull), 0);
  endtask

  task automatic t_std();
    int lo, hi;
    std_hi = 16'd20; std_lo = 16'd30; fast_sel = 1'b0;
    @(negedge clk); enable = 1'b1;
    measure(lo, hi);
    check("R3 std low", lo, 31);
    check("R4 std high", hi, 28);
    measure(lo, hi);
    check("R3 std low repeat", lo, 31);
    stop_gen();
  endtask

  task automatic t_fast();
    int lo, hi;
    fast_sel = 1'b1;
    @(negedge clk); enable = 1'b1;
    measure(lo, hi);
    check("R6 fast low", lo, 13);
    check("R6 fast high", hi, 17);
    stop_gen();
  endtask

  task automatic t_clamp();
    int lo, hi;
    fast_sel = 1'b0; std_hi = 16'd0; std_lo = 16'd2;
    @(negedge clk); enable = 1'b1;
    measure(lo, hi);
    check("R7 clamped low", lo, 7);
    check("R7 clamped high", hi, 14);
    stop_gen();
    std_hi = 16'd6; std_lo = 16'd6;
    @(negedge clk); enable = 1'b1;
    measure(lo, hi);
    check("R7 floor value low", lo, 7);
    stop_gen();
  endtask

  task automatic t_stretch();
    int lo, hi;
    std_hi = 16'd20; std_lo = 16'd30; fast_sel = 1'b0;
    stretch_cycles = 10;
    @(negedge clk); enable = 1'b1;
    measure(lo, hi);
    check("R5 stretched high", hi, 37);
    check("R3 low with stretch", lo, 31);
    stop_gen();
    stretch_cycles = 0;
  endtask

  task automatic t_ignore();
    int lo, hi;
    std_hi = 16'd20; std_lo = 16'd30; fast_sel = 1'b0;
    @(negedge clk); enable = 1'b1;
    repeat (4) @(negedge clk);
    std_hi = 16'd50; std_lo = 16'd8; fast_sel = 1'b1;
    measure(lo, hi);
    check("R8 low unchanged while enabled", lo, 31);
    check("R8 high unchanged while enabled", hi, 28);
    stop_gen();
    fast_sel = 1'b0;
    @(negedge clk); enable = 1'b1;
    measure(lo, hi);
    check("R8 new low after disable", lo, 9);
    check("R8 new high after disable", hi, 58);
    stop_gen();
  endtask

  task automatic t_disable();
    int lo;
    std_hi = 16'd20; std_lo = 16'd30;
    @(negedge clk); enable = 1'b1;
    @(negedge clk);
    check("R2 pull one cycle after enable", int'(scl_pull), 1);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R2 released after disable", int'(scl_pull), 0);
    enable = 1'b1;
    @(negedge clk);
    check("R2 restart pull", int'(scl_pull), 1);
    lo = 0;
    while (scl_pull) begin lo++; @(negedge clk); end
    check("R2 full low after restart", lo, 31);
    stop_gen();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 released after reset", int'(scl_pull), 0);
    t_std();
    t_fast();
    t_clamp();
    t_stretch();
    t_ignore();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule